// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder-Subtractor

This block takes two single-precision floating-point words and an operation select, and produces their sum or difference as a single-precision word one clock later. Each operand is split into sign, biased exponent and significand. The implicit leading bit is restored for normal numbers and left clear for denormals. The significand of the operand with the smaller exponent is shifted right until both exponents match. The two signed significands are then added in two's complement. A negative sum is turned back into sign and magnitude. The magnitude is normalized, and the word is repacked with every bit below the fraction field discarded.

The datapath is combinational from the input ports to one output register. The result register loads only in a cycle where the input is marked valid, and the output valid flag is that input valid delayed by one cycle. Inputs whose exponent field is all ones are not given any special meaning. Results are always truncated, never rounded.

Top module: `fp32_addsub`

## Requirements
- R1: For normal operands (exponent field 1..254) the true exponent is the field value minus 127 and the significand is 1.fraction; for example 0x3F800000 + 0x40000000 gives 0x40400000.
- R2: An operand with exponent field 0 is a denormal: its leading significand bit is 0 and its true exponent is -126, the same as for exponent field 1; for example 0x00400000 + 0x00800000 gives 0x00C00000.
- R3: The significand of the operand with the smaller exponent is shifted right by the exponent difference, and bits shifted out are dropped before the addition; 0x4B000000 + 0x3FC00000 gives 0x4B000001.
- R4: When the exponent difference is 24 or more, or the other operand is zero, the result equals the larger operand unchanged; 0x4B800000 + 0x3F800000 gives 0x4B800000.
- R5: With op_sub = 1 the sign of opb is inverted before the combination, so the result is opa - opb; with op_sub = 0 it is opa + opb.
- R6: When the signed significand sum is negative, its magnitude is used and the result sign bit (bit 31) is 1; 0xC0000000 + 0x3F800000 gives 0xBF800000.
- R7: The magnitude is normalized to a leading 1 in significand bit 23, with the exponent raised by one on a carry out or lowered by the left shift, and bits below the 23-bit fraction are truncated; 0x3F800001 + 0x3F800000 gives 0x40000000 and 0x3F800001 - 0x3F800000 gives 0x34000000.
- R8: The normalizing left shift never takes the exponent below -126; a result that still lacks a leading 1 there is encoded with exponent field 0 (denormal); 0x00800001 - 0x00800000 gives 0x00000001.
- R9: An exact zero result is 0x00000000 (positive sign), including -0 + -0 and x - x.
- R10: A result whose exponent field would reach 255 or more is encoded with exponent field 255, fraction 0 and the computed sign; 0x7F7FFFFF + 0x7F7FFFFF gives 0x7F800000.
- R11: out_valid is high exactly in the cycle after a cycle with in_valid high; result is updated only from a valid input and holds its value otherwise; back-to-back valid inputs each produce their own result.
- R12: While rst_n is low at a rising clock edge, out_valid and result are cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and select are valid this cycle |
| opa | input | 32 | First operand, single-precision word |
| opb | input | 32 | Second operand, single-precision word |
| op_sub | input | 1 | 0 adds, 1 subtracts opb from opa |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 32 | Truncated sum or difference |

## Verification
Same-sign additions with equal and nearby exponents exercise alignment and the carry-out renormalization. Opposite-sign pairs that leave a negative sum separate the magnitude recovery from the sign logic, and near-cancelling pairs drive the long left shift. Denormal pairs, and pairs whose difference falls into the denormal range, separate the exponent-floor clamp from ordinary normalization. Exponent gaps of 23 and 24 bracket the point where the smaller operand vanishes. Exact cancellation, negative zeros and the largest finite values probe the zero and saturation encodings. A deterministic pseudo-random sweep with near-equal exponents is compared against a behavioural model of the same truncating rules.

// File: rtl/fpas_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and types for the float adder-subtractor.
// Assumes the single-precision layout {sign, exponent, fraction}.
package fpas_pkg;
    localparam int EXP_W_DEF  = 8;
    localparam int FRAC_W_DEF = 23;

    // Which normalization path the magnitude takes
    typedef enum logic [1:0] {
        NRM_ZERO  = 2'd0,
        NRM_CARRY = 2'd1,
        NRM_LEFT  = 2'd2
    } nrm_case_t;
endpackage

// File: rtl/fpas_unpack.sv
`timescale 1ns/1ps
// Module: fpas_unpack
// Splits one float word into sign, effective exponent and full significand.
// A zero exponent field marks a denormal: hidden bit 0, effective field 1.
// sign_flip inverts the operand sign (used to turn an add into a subtract).
module fpas_unpack #(
    parameter int EXP_W  = fpas_pkg::EXP_W_DEF,
    parameter int FRAC_W = fpas_pkg::FRAC_W_DEF,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic              sign_flip,
    output logic              sign,
    output logic [EXP_W-1:0]  eff_exp,
    output logic [SIG_W-1:0]  sig
);
    logic [EXP_W-1:0] exp_field;
    logic             is_denorm;

    // Field extraction and hidden-bit restore
    always_comb begin
        exp_field = word[WORD_W-2 -: EXP_W];
        is_denorm = (exp_field == '0);
        sign      = word[WORD_W-1] ^ sign_flip;
        eff_exp   = is_denorm ? EXP_W'(1) : exp_field;
        sig       = {~is_denorm, word[FRAC_W-1:0]};
    end
endmodule

// File: rtl/fpas_align.sv
`timescale 1ns/1ps
// Module: fpas_align
// Orders two unpacked operands by exponent and right-shifts the smaller
// one's significand by the difference. Shifted-out bits are dropped; a
// difference of SIG_W or more leaves a zero significand. Ties keep A as big.
module fpas_align #(
    parameter int EXP_W = fpas_pkg::EXP_W_DEF,
    parameter int SIG_W = fpas_pkg::FRAC_W_DEF + 1
) (
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [SIG_W-1:0] a_sig,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [SIG_W-1:0] b_sig,
    output logic             big_sign,
    output logic [EXP_W-1:0] big_exp,
    output logic [SIG_W-1:0] big_sig,
    output logic             sml_sign,
    output logic [SIG_W-1:0] sml_sig
);
    logic             a_is_big;
    logic [EXP_W-1:0] diff;
    logic [SIG_W-1:0] sml_raw;

    // Operand ordering by effective exponent
    always_comb begin
        a_is_big = (a_exp >= b_exp);
        big_sign = a_is_big ? a_sign : b_sign;
        big_exp  = a_is_big ? a_exp  : b_exp;
        big_sig  = a_is_big ? a_sig  : b_sig;
        sml_sign = a_is_big ? b_sign : a_sign;
        sml_raw  = a_is_big ? b_sig  : a_sig;
        diff     = a_is_big ? (a_exp - b_exp) : (b_exp - a_exp);
    end

    // Alignment shift with flush when the gap exceeds the precision
    always_comb begin
        if (int'(diff) >= SIG_W) begin
            sml_sig = '0;
        end else begin
            sml_sig = sml_raw >> diff;
        end
    end
endmodule

// File: rtl/fpas_combine.sv
`timescale 1ns/1ps
// Module: fpas_combine
// Adds two signed significands in two's complement on an extended width
// and returns the result sign and magnitude. Width SIG_W+2 cannot overflow.
module fpas_combine #(
    parameter int SIG_W = fpas_pkg::FRAC_W_DEF + 1,
    localparam int SUM_W = SIG_W + 2,
    localparam int MAG_W = SIG_W + 1
) (
    input  logic             big_sign,
    input  logic [SIG_W-1:0] big_sig,
    input  logic             sml_sign,
    input  logic [SIG_W-1:0] sml_sig,
    output logic             neg,
    output logic [MAG_W-1:0] mag
);
    logic [SUM_W-1:0] big_ext;
    logic [SUM_W-1:0] sml_ext;
    logic [SUM_W-1:0] big_tc;
    logic [SUM_W-1:0] sml_tc;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] sum_neg;

    // Signed operands in two's complement
    always_comb begin
        big_ext = {2'b00, big_sig};
        sml_ext = {2'b00, sml_sig};
        big_tc  = big_sign ? (~big_ext + SUM_W'(1)) : big_ext;
        sml_tc  = sml_sign ? (~sml_ext + SUM_W'(1)) : sml_ext;
    end

    // Sum and conversion back to sign-magnitude
    always_comb begin
        sum     = big_tc + sml_tc;
        sum_neg = ~sum + SUM_W'(1);
        neg     = sum[SUM_W-1];
        mag     = neg ? sum_neg[MAG_W-1:0] : sum[MAG_W-1:0];
    end
endmodule

// File: rtl/fpas_normpack.sv
`timescale 1ns/1ps
// Module: fpas_normpack
// Normalizes a magnitude of SIG_W+1 bits to a leading 1 at bit SIG_W-1,
// limits the left shift so the exponent field stays >= 1 (else denormal),
// truncates low bits, saturates large exponents to all ones with a zero
// fraction, and encodes an exact zero as +0.
module fpas_normpack #(
    parameter int EXP_W  = fpas_pkg::EXP_W_DEF,
    parameter int FRAC_W = fpas_pkg::FRAC_W_DEF,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int MAG_W  = SIG_W + 1,
    localparam int XE_W   = EXP_W + 1
) (
    input  logic              neg,
    input  logic [MAG_W-1:0]  mag,
    input  logic [EXP_W-1:0]  big_exp,
    output logic [WORD_W-1:0] word
);
    import fpas_pkg::*;

    localparam logic [XE_W-1:0] EXP_MAX = {1'b0, {EXP_W{1'b1}}};

    // Highest set bit of the magnitude (0 when empty)
    function automatic logic [XE_W-1:0] lead_pos(input logic [MAG_W-1:0] v);
        logic [XE_W-1:0] p;
        p = '0;
        for (int i = 0; i < MAG_W; i++) begin
            if (v[i]) p = XE_W'(i);
        end
        return p;
    endfunction

    nrm_case_t       ncase;
    logic [XE_W-1:0] xbig;
    logic [XE_W-1:0] lpos;
    logic [XE_W-1:0] need;
    logic [XE_W-1:0] room;
    logic [XE_W-1:0] shamt;
    logic [MAG_W-1:0] shifted;
    logic [SIG_W-1:0] sig_n;
    logic [XE_W-1:0] exp_n;

    // Classification of the magnitude
    always_comb begin
        if (mag == '0) begin
            ncase = NRM_ZERO;
        end else if (mag[MAG_W-1]) begin
            ncase = NRM_CARRY;
        end else begin
            ncase = NRM_LEFT;
        end
    end

    // Left-shift amount bounded by the exponent floor
    always_comb begin
        xbig    = {1'b0, big_exp};
        lpos    = lead_pos(mag);
        need    = XE_W'(SIG_W - 1) - lpos;
        room    = xbig - XE_W'(1);
        shamt   = (need < room) ? need : room;
        shifted = mag << shamt;
    end

    // Normalized significand and exponent per path
    always_comb begin
        case (ncase)
            NRM_CARRY: begin
                sig_n = mag[MAG_W-1:1];
                exp_n = xbig + XE_W'(1);
            end
            NRM_LEFT: begin
                sig_n = shifted[SIG_W-1:0];
                exp_n = shifted[SIG_W-1] ? (xbig - shamt) : '0;
            end
            default: begin
                sig_n = '0;
                exp_n = '0;
            end
        endcase
    end

    // Final packing with zero and saturation encodings
    always_comb begin
        if (ncase == NRM_ZERO) begin
            word = '0;
        end else if (exp_n >= EXP_MAX) begin
            word = {neg, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            word = {neg, exp_n[EXP_W-1:0], sig_n[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fp32_addsub.sv
`timescale 1ns/1ps
// Module: fp32_addsub (top)
// Truncating float add/subtract with one output register stage.
// Assumes exponent-all-ones inputs carry no special meaning.
// result loads only when in_valid is high; out_valid follows in_valid.
module fp32_addsub #(
    parameter int EXP_W  = fpas_pkg::EXP_W_DEF,
    parameter int FRAC_W = fpas_pkg::FRAC_W_DEF,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int MAG_W  = SIG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic              op_sub,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    logic [1:0]       u_sign;
    logic [EXP_W-1:0] u_exp [2];
    logic [SIG_W-1:0] u_sig [2];

    logic             big_sign, sml_sign;
    logic [EXP_W-1:0] big_exp;
    logic [SIG_W-1:0] big_sig, sml_sig;
    logic             res_neg;
    logic [MAG_W-1:0] res_mag;
    logic [WORD_W-1:0] res_word;

    // One unpacker per operand; only operand 1 sees the subtract flip
    for (genvar g = 0; g < 2; g++) begin : g_unp
        fpas_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
            .word      ((g == 0) ? opa : opb),
            .sign_flip ((g == 0) ? 1'b0 : op_sub),
            .sign      (u_sign[g]),
            .eff_exp   (u_exp[g]),
            .sig       (u_sig[g])
        );
    end

    fpas_align #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_align (
        .a_sign   (u_sign[0]),
        .a_exp    (u_exp[0]),
        .a_sig    (u_sig[0]),
        .b_sign   (u_sign[1]),
        .b_exp    (u_exp[1]),
        .b_sig    (u_sig[1]),
        .big_sign (big_sign),
        .big_exp  (big_exp),
        .big_sig  (big_sig),
        .sml_sign (sml_sign),
        .sml_sig  (sml_sig)
    );

    fpas_combine #(.SIG_W(SIG_W)) u_comb (
        .big_sign (big_sign),
        .big_sig  (big_sig),
        .sml_sign (sml_sign),
        .sml_sig  (sml_sig),
        .neg      (res_neg),
        .mag      (res_mag)
    );

    fpas_normpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .neg     (res_neg),
        .mag     (res_mag),
        .big_exp (big_exp),
        .word    (res_word)
    );

    // Output register: capture on valid input, flag follows one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_word;
            end
        end
    end
endmodule

// File: rtl/fpas_chk.sv
`timescale 1ns/1ps
// Module: fpas_chk
// Port-level temporal checks for fp32_addsub, bound to every instance.
module fpas_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] opa,
    input logic [WORD_W-1:0] opb,
    input logic              out_valid,
    input logic [WORD_W-1:0] result
);
    localparam int EXP_W = 8;

    // R11: a valid input yields out_valid on the next cycle
    p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11: no valid input means no output flag and an unchanged result
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R9: a zero magnitude is always emitted with a positive sign
    p_zero_positive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[WORD_W-2:0] == '0) |-> !result[WORD_W-1]);

    // R10: a saturated exponent always carries a zero fraction
    p_inf_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[WORD_W-2 -: EXP_W] == '1) |->
        (result[WORD_W-EXP_W-2:0] == '0));

    // R4: a zero opb leaves a nonzero finite opa unchanged
    p_zero_operand_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opb[WORD_W-2:0] == '0 && opa[WORD_W-2:0] != '0 &&
         opa[WORD_W-2 -: EXP_W] != '1) |=> (result == $past(opa)));
endmodule

bind fp32_addsub fpas_chk #(.WORD_W(32)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_fp32_addsub.sv
`timescale 1ns/1ps
// Directed bench for fp32_addsub: one task per scenario.
module sim_fp32_addsub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        op_sub = 1'b0;
    logic        out_valid;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fp32_addsub u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opa       (opa),
        .opb       (opb),
        .op_sub    (op_sub),
        .out_valid (out_valid),
        .result    (result)
    );

    // Behavioural reference following the truncating rules
    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic sub);
        int ea, eb, e, d;
        longint ma, mb, m, s;
        logic sa, sb, ng;
        ea = (a[30:23] == 8'd0) ? 1 : int'(a[30:23]);
        eb = (b[30:23] == 8'd0) ? 1 : int'(b[30:23]);
        ma = longint'({40'd0, (a[30:23] != 8'd0), a[22:0]});
        mb = longint'({40'd0, (b[30:23] != 8'd0), b[22:0]});
        sa = a[31];
        sb = b[31] ^ sub;
        if (ea >= eb) begin
            e = ea; d = ea - eb;
            mb = (d >= 24) ? 64'sd0 : (mb >>> d);
        end else begin
            e = eb; d = eb - ea;
            ma = (d >= 24) ? 64'sd0 : (ma >>> d);
        end
        s  = (sa ? -ma : ma) + (sb ? -mb : mb);
        ng = (s < 0);
        m  = ng ? -s : s;
        if (m == 0) return 32'h0;
        if (m >= 64'sd16777216) begin m = m >>> 1; e++; end
        while (m < 64'sd8388608 && e > 1) begin m = m <<< 1; e--; end
        if (m < 64'sd8388608) e = 0;
        if (e >= 255) return {ng, 8'hFF, 23'd0};
        return {ng, 8'(e), m[22:0]};
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Apply one vector, check result one cycle later and the idle cycle after
    task automatic run_vec(input string req, input logic [31:0] a, input logic [31:0] b,
                           input logic sub, input logic [31:0] exp);
        @(negedge clk);
        opa = a; opb = b; op_sub = sub; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        opa = ~a; opb = ~b;
        check1(req, out_valid, 1'b1);
        check32(req, result, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b1; opa = 32'h3F800000; opb = 32'h3F800000;
        repeat (3) @(negedge clk);
        check1("R12", out_valid, 1'b0);
        check32("R12", result, 32'h0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_normal();
        run_vec("R1", 32'h3F800000, 32'h40000000, 1'b0, 32'h40400000);
        run_vec("R1", 32'h3F800000, 32'h3F400000, 1'b0, 32'h3FE00000);
        run_vec("R1", 32'h3FFFFFFF, 32'h3FFFFFFF, 1'b0, 32'h407FFFFF);
    endtask

    task automatic t_sub();
        run_vec("R5", 32'h40400000, 32'h3F800000, 1'b1, 32'h40000000);
        run_vec("R5", 32'h3F800000, 32'h40000000, 1'b1, 32'hBF800000);
        run_vec("R5", 32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000);
    endtask

    task automatic t_negative();
        run_vec("R6", 32'hC0000000, 32'h3F800000, 1'b0, 32'hBF800000);
        run_vec("R6", 32'hC0400000, 32'hC0000000, 1'b0, 32'hC0A00000);
    endtask

    task automatic t_denormal();
        run_vec("R2", 32'h00400000, 32'h00800000, 1'b0, 32'h00C00000);
        run_vec("R2", 32'h00400000, 32'h00400000, 1'b0, 32'h00800000);
        run_vec("R2", 32'h00000001, 32'h00000001, 1'b0, 32'h00000002);
    endtask

    task automatic t_align();
        run_vec("R3", 32'h4B000000, 32'h3F800000, 1'b0, 32'h4B000001);
        run_vec("R3", 32'h4B000000, 32'h3FC00000, 1'b0, 32'h4B000001);
        run_vec("R4", 32'h4B800000, 32'h3F800000, 1'b0, 32'h4B800000);
        run_vec("R4", 32'h3F800000, 32'hCB800000, 1'b1, 32'h4B800000);
        run_vec("R4", 32'hC1200000, 32'h00000000, 1'b0, 32'hC1200000);
    endtask

    task automatic t_normalize();
        run_vec("R7", 32'h3F800001, 32'h3F800000, 1'b0, 32'h40000000);
        run_vec("R7", 32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000);
    endtask

    task automatic t_subnormal_res();
        run_vec("R8", 32'h00800001, 32'h00800000, 1'b1, 32'h00000001);
        run_vec("R8", 32'h01000000, 32'h00C00000, 1'b1, 32'h00400000);
    endtask

    task automatic t_zero();
        run_vec("R9", 32'h40490FDB, 32'h40490FDB, 1'b1, 32'h00000000);
        run_vec("R9", 32'h80000000, 32'h80000000, 1'b0, 32'h00000000);
        run_vec("R9", 32'hC0490FDB, 32'h40490FDB, 1'b0, 32'h00000000);
    endtask

    task automatic t_overflow();
        run_vec("R10", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000);
        run_vec("R10", 32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000);
    endtask

    // R11: idle cycle holds, back-to-back vectors each appear
    task automatic t_valid_timing();
        run_vec("R11", 32'h3F800000, 32'h40000000, 1'b0, 32'h40400000);
        @(negedge clk);
        check1("R11", out_valid, 1'b0);
        check32("R11", result, 32'h40400000);
        opa = 32'h40400000; opb = 32'h3F800000; op_sub = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check1("R11", out_valid, 1'b1);
        check32("R11", result, 32'h40000000);
        opa = 32'hC0000000; opb = 32'h3F800000; op_sub = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check1("R11", out_valid, 1'b1);
        check32("R11", result, 32'hBF800000);
        @(negedge clk);
        check1("R11", out_valid, 1'b0);
        check32("R11", result, 32'hBF800000);
    endtask

    // R1 R3 R6 R7 R8: pseudo-random sweep with near-equal exponents
    task automatic t_sweep();
        logic [31:0] x;
        logic [31:0] a, b;
        x = 32'h1234ABCD;
        for (int i = 0; i < 400; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            a = x;
            if (a[30:23] == 8'hFF) a[30] = 1'b0;
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            b = x;
            if (i % 2 == 0 && a[30:23] < 8'd250) b[30:23] = a[30:23] + 8'(x[1:0]);
            if (i % 7 == 0) b[30:23] = 8'd0;
            if (b[30:23] == 8'hFF) b[30] = 1'b0;
            run_vec("R7", a, b, x[9], model(a, b, x[9]));
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_normal();
        t_sub();
        t_negative();
        t_denormal();
        t_align();
        t_normalize();
        t_subnormal_res();
        t_zero();
        t_overflow();
        t_valid_timing();
        t_sweep();
        repeat (2) @(negedge clk);
        report();
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule